// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces the address sequence for one transfer through a ring buffer in memory. A single start pulse captures four values: an addressing mode, the ring's lowest address, its capacity minus one, and the first address. One cycle later the block validates that first address against the ring. It then shows one address at a time and moves to the next one each time the consumer pulses `adv`. When it moves past the ring's top location it returns to the lowest address. The block carries no data. A separate engine uses these addresses to move samples.

The address that must not be crossed is `last = base + size_m1`. If that sum overflows the address width, `last` is clamped to the all-ones address. The checked start behaves differently in each mode:
- FIFO mode: a first address below the ring is raised to the base. A first address beyond `last` is a fault. The fault is flagged and held, and the block does not lock up.
- Scratch mode: a first address beyond `last` makes the whole transfer plain counting with no wrap.
- Plain mode: the ring description is not used at all.

The controller has four states:
- `ST_IDLE`: after reset, nothing is presented.
- `ST_CHECK`: one cycle, entered on every start pulse.
- `ST_RUN`: addresses are presented.
- `ST_FAULT`: the error is held.

Its transitions:
- IDLE→CHECK, RUN→CHECK and FAULT→CHECK on `start`.
- CHECK→RUN on an accepted start.
- CHECK→FAULT on a rejected FIFO start.
- RUN→RUN on `adv`, when the address steps.

Top module: `ring_addr_gen`

## Requirements
- R1: While reset is held and after it is released, `addr_valid`, `err` and `lin` are all 0.
- R2: A `start` pulse at clock edge k captures `cfg_mode`, `cfg_base`, `cfg_size_m1` and `cfg_first`. At edge k+1 (the CHECK cycle) `addr_valid` and `err` are 0. From edge k+2 on, the first address or the fault is visible. Changes to the config inputs after the pulse have no effect.
- R3: The ring's top location is `base + size_m1`. If that sum does not fit in AW bits, the top location is 2^AW-1.
- R4: In ring addressing (`lin`=0), `adv` while valid moves the address from the top location to `base`, and from any other address to address+1.
- R5: In FIFO mode (`cfg_mode`=2'b01), a first address below `base` is replaced by `base`.
- R6: In FIFO mode, a first address above the top location sets `err`=1 with `addr_valid`=0. Both hold until the next `start`, whatever `adv` does.
- R7: In scratch mode (`cfg_mode`=2'b10), a first address above the top location gives `lin`=1 with plain +1 steps. Otherwise the transfer is ring addressed, starting exactly at the first address given.
- R8: In plain mode (`cfg_mode`=2'b00 or 2'b11), base and size are ignored and `lin`=1. Each step is +1 modulo 2^AW.
- R9: While `adv` is 0, or while no address is valid, the presented address does not change.
- R10: A `start` while addresses are running abandons the current transfer and begins the new one, with the timing of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a transfer |
| cfg_mode | input | 2 | 00 plain, 01 FIFO, 10 scratch, 11 plain |
| cfg_base | input | AW | Lowest address of the ring |
| cfg_size_m1 | input | AW | Ring capacity minus one |
| cfg_first | input | AW | First address (current address or offset) |
| adv | input | 1 | Step to the next address |
| addr | output | AW | Presented address |
| addr_valid | output | 1 | `addr` is meaningful |
| err | output | 1 | FIFO start fault, held until the next start |
| lin | output | 1 | Transfer uses plain counting |

## Verification
The bench builds the block with AW=8, which makes the whole 256-entry address space cheap to reach.

The sweep covers:
- four bases and four ring sizes, including pairs whose sum passes 255, so the clamped top location and its wrap are exercised;
- all four mode codes;
- forty first addresses per ring, including the top location, the location just above it, and the address just below the base.

With only eight address bits, both the ring wrap and the modulo-256 roll of plain counting come up within a few steps.

// File: rtl/ring_pkg.sv
package ring_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN   = 2'b00,
        MODE_FIFO    = 2'b01,
        MODE_SCRATCH = 2'b10,
        MODE_PLAIN2  = 2'b11
    } ring_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RUN,
        ST_FAULT
    } ring_state_e;

endpackage

// File: rtl/ring_top_calc.sv
module ring_top_calc #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size_m1,
    output logic [AW-1:0] last
);
    localparam logic [AW-1:0] ALL_ONES = '1;

    logic [AW:0] sum_w;

    always_comb begin
        sum_w = {1'b0, base} + {1'b0, size_m1};
        last  = sum_w[AW] ? ALL_ONES : sum_w[AW-1:0];
    end
endmodule

// File: rtl/ring_start_check.sv
module ring_start_check
    import ring_pkg::*;
#(
    parameter int AW = 24
) (
    input  ring_mode_e    mode,
    input  logic [AW-1:0] first,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] last,
    output logic [AW-1:0] start_addr,
    output logic          fault,
    output logic          linear
);
    always_comb begin
        start_addr = first;
        fault      = 1'b0;
        linear     = 1'b0;
        unique case (mode)
            MODE_FIFO: begin
                if (first < base) begin
                    start_addr = base;
                end else if (first > last) begin
                    fault = 1'b1;
                end
            end
            MODE_SCRATCH: begin
                linear = (first > last);
            end
            MODE_PLAIN, MODE_PLAIN2: begin
                linear = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/ring_step.sv
module ring_step #(
    parameter int AW = 24
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] last,
    input  logic          linear,
    output logic [AW-1:0] next
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    always_comb begin
        if (!linear && (cur == last)) begin
            next = base;
        end else begin
            next = cur + ONE;
        end
    end
endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen
    import ring_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    cfg_mode,
    input  logic [AW-1:0] cfg_base,
    input  logic [AW-1:0] cfg_size_m1,
    input  logic [AW-1:0] cfg_first,
    input  logic          adv,
    output logic [AW-1:0] addr,
    output logic          addr_valid,
    output logic          err,
    output logic          lin
);
    ring_state_e   state_q, state_d;
    ring_mode_e    mode_q;
    logic [AW-1:0] base_q, size_q, first_q, addr_q;
    logic          lin_q;

    logic [AW-1:0] last_w, start_addr_w, next_w;
    logic          fault_w, linear_w;

    ring_top_calc #(.AW(AW)) top_calc_i (
        .base    (base_q),
        .size_m1 (size_q),
        .last    (last_w)
    );

    ring_start_check #(.AW(AW)) start_check_i (
        .mode       (mode_q),
        .first      (first_q),
        .base       (base_q),
        .last       (last_w),
        .start_addr (start_addr_w),
        .fault      (fault_w),
        .linear     (linear_w)
    );

    ring_step #(.AW(AW)) step_i (
        .cur    (addr_q),
        .base   (base_q),
        .last   (last_w),
        .linear (lin_q),
        .next   (next_w)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_CHECK;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_CHECK: state_d = fault_w ? ST_FAULT : ST_RUN;
                ST_RUN:   state_d = ST_RUN;
                ST_FAULT: state_d = ST_FAULT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= MODE_PLAIN;
            base_q  <= '0;
            size_q  <= '0;
            first_q <= '0;
            addr_q  <= '0;
            lin_q   <= 1'b0;
        end else if (start) begin
            mode_q  <= ring_mode_e'(cfg_mode);
            base_q  <= cfg_base;
            size_q  <= cfg_size_m1;
            first_q <= cfg_first;
        end else if (state_q == ST_CHECK) begin
            addr_q <= start_addr_w;
            lin_q  <= linear_w;
        end else if (state_q == ST_RUN && adv) begin
            addr_q <= next_w;
        end
    end

    // outputs
    always_comb begin
        addr       = addr_q;
        addr_valid = 1'b0;
        err        = 1'b0;
        lin        = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_CHECK: ;
            ST_RUN: begin
                addr_valid = 1'b1;
                lin        = lin_q;
            end
            ST_FAULT: err = 1'b1;
        endcase
    end
endmodule

// File: rtl/ring_addr_gen_chk.sv
module ring_addr_gen_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          adv,
    input logic [AW-1:0] addr,
    input logic          addr_valid,
    input logic          err,
    input logic          lin,
    input logic [AW-1:0] base_q,
    input logic [AW-1:0] last_w
);
    localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

    // R2
    check_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!addr_valid && !err));

    // R6
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err && addr_valid));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !adv && !start) |=> (addr_valid && $stable(addr)));

    // R8
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && lin && adv && !start) |=> (addr == $past(addr) + ONE));

    // R4
    ring_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !lin && adv && !start && addr == last_w) |=> (addr == base_q));
endmodule

bind ring_addr_gen ring_addr_gen_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .adv        (adv),
    .addr       (addr),
    .addr_valid (addr_valid),
    .err        (err),
    .lin        (lin),
    .base_q     (base_q),
    .last_w     (last_w)
);

// File: tb/ring_addr_gen_tb.sv
module ring_addr_gen_tb_top;
    localparam int AW = 8;
    localparam int AMAX = 255;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [1:0]    cfg_mode;
    logic [AW-1:0] cfg_base, cfg_size_m1, cfg_first;
    logic          adv;
    logic [AW-1:0] addr;
    logic          addr_valid, err, lin;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    ring_addr_gen #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_base(cfg_base), .cfg_size_m1(cfg_size_m1), .cfg_first(cfg_first),
        .adv(adv), .addr(addr), .addr_valid(addr_valid), .err(err), .lin(lin)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_one(input int m, input int base, input int size, input int st);
        int  last, a;
        bit  e_lin, e_fault;
        string tag;
        last = (base + size > AMAX) ? AMAX : base + size;
        @(negedge clk);
        start = 1'b1; cfg_mode = m[1:0]; cfg_base = base[AW-1:0];
        cfg_size_m1 = size[AW-1:0]; cfg_first = st[AW-1:0]; adv = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cfg_mode = ~cfg_mode; cfg_base = ~cfg_base;
        cfg_size_m1 = ~cfg_size_m1; cfg_first = ~cfg_first;
        chk("R2 gap valid", int'(addr_valid), 0);
        chk("R2 gap err", int'(err), 0);
        e_lin   = (m == 0) || (m == 3) || (m == 2 && st > last);
        e_fault = (m == 1) && (st > last);
        a       = (m == 1 && st < base) ? base : st;
        if (m == 1 && st < base) tag = "R5";
        else if (e_lin && m == 2) tag = "R7";
        else if (e_lin) tag = "R8";
        else tag = "R2";
        @(negedge clk);
        chk(e_fault ? "R6 err" : "R2 err", int'(err), int'(e_fault));
        chk("R10 valid", int'(addr_valid), int'(!e_fault));
        if (!e_fault) begin
            chk({tag, " first addr"}, int'(addr), a);
            chk({tag, " lin"}, int'(lin), int'(e_lin));
        end
        for (int i = 0; i < 8; i++) begin
            adv = (i % 3 != 2);
            @(negedge clk);
            if (e_fault) begin
                chk("R6 held err", int'(err), 1);
                chk("R6 held valid", int'(addr_valid), 0);
            end else if (adv) begin
                if (e_lin) begin
                    a = (a + 1) & AMAX;
                    chk(m == 2 ? "R7 step" : "R8 step", int'(addr), a);
                end else begin
                    a = (a == last) ? base : a + 1;
                    chk((base + size > AMAX) ? "R3 step" : "R4 step", int'(addr), a);
                end
            end else begin
                chk("R9 hold", int'(addr), a);
            end
        end
        adv = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int bases[4] = '{0, 5, 200, 250};
        int sizes[4] = '{0, 3, 10, 60};
        rst_n = 1'b0; start = 1'b0; cfg_mode = '0; cfg_base = '0;
        cfg_size_m1 = '0; cfg_first = '0; adv = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", int'(addr_valid), 0);
        chk("R1 err in reset", int'(err), 0);
        chk("R1 lin in reset", int'(lin), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 valid after reset", int'(addr_valid), 0);
        chk("R1 err after reset", int'(err), 0);
        for (int bi = 0; bi < 4; bi++) begin
            for (int si = 0; si < 4; si++) begin
                for (int m = 0; m < 4; m++) begin
                    for (int k = 0; k < 40; k++) begin
                        int b, s, last, st;
                        b = bases[bi];
                        s = sizes[si];
                        last = (b + s > AMAX) ? AMAX : b + s;
                        if (k < 36) st = k * 7;
                        else if (k == 36) st = last;
                        else if (k == 37) st = (last + 1) & AMAX;
                        else if (k == 38) st = (b - 1) & AMAX;
                        else st = b;
                        run_one(m, b, s, st);
                    end
                end
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule